// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache with LRU Replacement

This block is a small read-only data cache placed between a requester that issues byte-address reads and a backing memory that delivers whole 8-byte blocks. Each address is split into three fields: a tag, a set index and a byte offset. Each of the two sets holds two lines. A line is a valid flag, a stored tag and an 8-byte data block. A read compares the address tag against both lines of the indexed set. A valid line with an equal tag is a hit, and the block answers from its own storage one cycle after the request.

On a miss the cache raises `busy` and asks the memory for the block that contains the address. It waits for the memory to return that block, installs it in the indexed set and answers the requester with the selected byte. The line to overwrite is chosen in this order: an empty line first, way 0 when both lines are empty, and otherwise the least-recently-used line. Every hit and every fill updates one replacement bit per set.

The requester must not issue a read while `busy` is high. Any request made during that time is dropped. Each response carries a flag that says whether the access hit or missed.

Top module: `cache_2way_lru`

## Requirements
- R1: After reset `busy`, `resp_valid` and `mem_req` are 0, and every line is empty, so the first read of any address is a miss.
- R2: Address fields with the default parameters: offset is `cpu_addr[2:0]`, set index is `cpu_addr[3]`, tag is `cpu_addr[7:4]`. `mem_addr` is the block address `cpu_addr[7:3]`. In `mem_block`, byte k occupies bits [8k+7:8k], and `resp_data` is byte number offset of the block.
- R3: A read accepted while `busy` is low that finds a valid line with an equal tag in the indexed set produces, on the next cycle, `resp_valid`=1 and `resp_hit`=1 with the cached byte. `mem_req` stays 0.
- R4: A read accepted while `busy` is low that misses raises `busy` and `mem_req` on the next cycle, with `mem_addr` holding the block address. Both stay high, and `mem_addr` stays stable, until `mem_valid` is sampled high.
- R5: In the cycle after `mem_req` and `mem_valid` are both high, `resp_valid`=1, `resp_hit`=0 and `resp_data` is the requested byte of `mem_block`, while `busy` and `mem_req` are 0. The installed block then hits on later reads.
- R6: A miss fills an empty line of the indexed set before any valid line is evicted. Two different blocks that map to the same set can therefore both be resident after two misses.
- R7: When both lines of the indexed set are valid, a miss evicts the line touched least recently. Both hits and fills count as touches.
- R8: A request made while `busy` is high is ignored. `mem_valid` while `mem_req` is low is ignored. Neither event produces a response or changes which blocks are cached.
- R9: The two sets are independent: fills and evictions in one set never remove lines from the other set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Read request, accepted when `busy` is low |
| cpu_addr | input | ADDR_W | Byte address of the read |
| busy | output | 1 | Miss in progress; requests are dropped |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Response was a hit (1) or a filled miss (0) |
| resp_data | output | 8 | Requested byte |
| mem_req | output | 1 | Block fetch request to memory |
| mem_addr | output | ADDR_W-3 | Block address of the fetch |
| mem_valid | input | 1 | Memory returns the block this cycle |
| mem_block | input | 64 | Returned block, byte k at bits [8k+7:8k] |

## Verification
The bench drives a conflict sequence in one set. A cache that replaced the most recently used line, or that ignored hits when updating the replacement bit, would return a hit where a miss is due and would skip a fetch. It also fills a set from empty. A design that evicted a valid line while an empty one remained would lose a block that should still hit.

Requests made during a pending fetch, and stray `mem_valid` pulses while the cache is idle, are used to expose a controller that accepts work while busy or that installs unrequested data. Memory latency is varied from zero to three cycles, and a mid-run reset catches valid flags that survive reset.

// File: rtl/cache_pkg.sv
package cache_pkg;
    localparam int WAYS  = 2;
    localparam int WAY_W = 1;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } ctrl_state_e;
endpackage

// File: rtl/cache_way.sv
module cache_way #(
    parameter int SETS    = 2,
    parameter int IDX_W   = 1,
    parameter int TAG_W   = 4,
    parameter int BLOCK_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               rd_valid,
    output logic [TAG_W-1:0]   rd_tag,
    output logic [BLOCK_W-1:0] rd_block,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [BLOCK_W-1:0] wr_block
);
    logic [SETS-1:0]    valid_d, valid_q;
    logic [TAG_W-1:0]   tag_d   [SETS];
    logic [TAG_W-1:0]   tag_q   [SETS];
    logic [BLOCK_W-1:0] block_d [SETS];
    logic [BLOCK_W-1:0] block_q [SETS];

    always_comb begin
        valid_d = valid_q;
        tag_d   = tag_q;
        block_d = block_q;
        if (wr_en) begin
            valid_d[wr_idx] = 1'b1;
            tag_d[wr_idx]   = wr_tag;
            block_d[wr_idx] = wr_block;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            tag_q   <= '{default: '0};
            block_q <= '{default: '0};
        end else begin
            valid_q <= valid_d;
            tag_q   <= tag_d;
            block_q <= block_d;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_block = block_q[rd_idx];
endmodule

// File: rtl/cache_hit_check.sv
module cache_hit_check
    import cache_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic [WAYS-1:0]  way_valid,
    input  logic [TAG_W-1:0] way_tag [WAYS],
    input  logic [TAG_W-1:0] addr_tag,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = way_valid[w] && (way_tag[w] == addr_tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/cache_lru.sv
module cache_lru
    import cache_pkg::*;
#(
    parameter int SETS  = 2,
    parameter int IDX_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_idx,
    input  logic [WAYS-1:0]  look_valid,
    output logic [WAY_W-1:0] victim_way,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic [WAY_W-1:0] touch_way
);
    logic [SETS-1:0] evict_d, evict_q;

    always_comb begin
        evict_d = evict_q;
        if (touch_en) evict_d[touch_idx] = ~touch_way;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evict_q <= '0;
        else        evict_q <= evict_d;
    end

    always_comb begin
        if (!look_valid[0])      victim_way = 1'b0;
        else if (!look_valid[1]) victim_way = 1'b1;
        else                     victim_way = evict_q[look_idx];
    end
endmodule

// File: rtl/cache_2way_lru.sv
module cache_2way_lru
    import cache_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int NUM_SETS    = 2,
    parameter int BLOCK_BYTES = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cpu_req,
    input  logic [ADDR_W-1:0]             cpu_addr,
    output logic                          busy,
    output logic                          resp_valid,
    output logic                          resp_hit,
    output logic [7:0]                    resp_data,
    output logic                          mem_req,
    output logic [ADDR_W-$clog2(BLOCK_BYTES)-1:0] mem_addr,
    input  logic                          mem_valid,
    input  logic [BLOCK_BYTES*8-1:0]      mem_block
);
    localparam int OFF_W   = $clog2(BLOCK_BYTES);
    localparam int IDX_W   = $clog2(NUM_SETS);
    localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
    localparam int BLOCK_W = BLOCK_BYTES * 8;
    localparam int BADDR_W = ADDR_W - OFF_W;

    typedef struct packed {
        ctrl_state_e       state;
        logic [ADDR_W-1:0] addr;
        logic [WAY_W-1:0]  victim;
        logic              resp_valid;
        logic              resp_hit;
        logic [7:0]        resp_data;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    function automatic logic [7:0] pick_byte(logic [BLOCK_W-1:0] blk, logic [OFF_W-1:0] off);
        return blk[{off, 3'b000} +: 8];
    endfunction

    logic [OFF_W-1:0] req_off, held_off;
    logic [IDX_W-1:0] req_idx, held_idx;
    logic [TAG_W-1:0] req_tag, held_tag;

    assign req_off  = cpu_addr[OFF_W-1:0];
    assign req_idx  = cpu_addr[OFF_W +: IDX_W];
    assign req_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign held_off = ctrl_q.addr[OFF_W-1:0];
    assign held_idx = ctrl_q.addr[OFF_W +: IDX_W];
    assign held_tag = ctrl_q.addr[ADDR_W-1 -: TAG_W];

    logic [WAYS-1:0]    way_valid;
    logic [TAG_W-1:0]   way_tag   [WAYS];
    logic [BLOCK_W-1:0] way_block [WAYS];
    logic [WAYS-1:0]    way_wr;
    logic               fill_en;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign way_wr[w] = fill_en && (ctrl_q.victim == WAY_W'(w));

        cache_way #(
            .SETS    (NUM_SETS),
            .IDX_W   (IDX_W),
            .TAG_W   (TAG_W),
            .BLOCK_W (BLOCK_W)
        ) u_way (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_idx   (req_idx),
            .rd_valid (way_valid[w]),
            .rd_tag   (way_tag[w]),
            .rd_block (way_block[w]),
            .wr_en    (way_wr[w]),
            .wr_idx   (held_idx),
            .wr_tag   (held_tag),
            .wr_block (mem_block)
        );
    end

    logic             hit;
    logic [WAY_W-1:0] hit_way;

    cache_hit_check #(
        .TAG_W (TAG_W)
    ) u_hit (
        .way_valid (way_valid),
        .way_tag   (way_tag),
        .addr_tag  (req_tag),
        .hit       (hit),
        .hit_way   (hit_way)
    );

    logic             touch_en;
    logic [IDX_W-1:0] touch_idx;
    logic [WAY_W-1:0] touch_way;
    logic [WAY_W-1:0] victim_way;

    cache_lru #(
        .SETS  (NUM_SETS),
        .IDX_W (IDX_W)
    ) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_idx   (req_idx),
        .look_valid (way_valid),
        .victim_way (victim_way),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .touch_way  (touch_way)
    );

    always_comb begin
        ctrl_d            = ctrl_q;
        ctrl_d.resp_valid = 1'b0;
        ctrl_d.resp_hit   = 1'b0;
        fill_en           = 1'b0;
        touch_en          = 1'b0;
        touch_idx         = req_idx;
        touch_way         = hit_way;
        case (ctrl_q.state)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (hit) begin
                        ctrl_d.resp_valid = 1'b1;
                        ctrl_d.resp_hit   = 1'b1;
                        ctrl_d.resp_data  = pick_byte(way_block[hit_way], req_off);
                        touch_en          = 1'b1;
                    end else begin
                        ctrl_d.state  = ST_FILL;
                        ctrl_d.addr   = cpu_addr;
                        ctrl_d.victim = victim_way;
                    end
                end
            end
            ST_FILL: begin
                if (mem_valid) begin
                    fill_en           = 1'b1;
                    ctrl_d.resp_valid = 1'b1;
                    ctrl_d.resp_data  = pick_byte(mem_block, held_off);
                    ctrl_d.state      = ST_IDLE;
                    touch_en          = 1'b1;
                    touch_idx         = held_idx;
                    touch_way         = ctrl_q.victim;
                end
            end
            default: ctrl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{state: ST_IDLE, addr: '0, victim: '0,
                        resp_valid: 1'b0, resp_hit: 1'b0, resp_data: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign busy       = (ctrl_q.state != ST_IDLE);
    assign mem_req    = (ctrl_q.state == ST_FILL);
    assign mem_addr   = ctrl_q.addr[ADDR_W-1:OFF_W];
    assign resp_valid = ctrl_q.resp_valid;
    assign resp_hit   = ctrl_q.resp_hit;
    assign resp_data  = ctrl_q.resp_data;
endmodule

// File: rtl/cache_2way_lru_checker.sv
module cache_2way_lru_checker #(
    parameter int BADDR_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cpu_req,
    input logic               busy,
    input logic               resp_valid,
    input logic               resp_hit,
    input logic               mem_req,
    input logic [BADDR_W-1:0] mem_addr,
    input logic               mem_valid
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!busy && !resp_valid && !mem_req));

    assert_accept_reacts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !busy) |=> ((resp_valid && resp_hit) || mem_req));

    assert_hit_no_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit) |-> !mem_req);

    assert_wait_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && busy && $stable(mem_addr)));

    assert_fill_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_valid) |=> (resp_valid && !resp_hit && !mem_req && !busy));

    assert_no_stray_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> ($past(cpu_req && !busy) || $past(mem_req && mem_valid)));
endmodule

bind cache_2way_lru cache_2way_lru_checker #(.BADDR_W(BADDR_W)) u_checker (.*);

// File: tb/cache_2way_lru_bench.sv
`timescale 1ns/1ps
module cache_2way_lru_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic        busy, resp_valid, resp_hit;
    logic [7:0]  resp_data;
    logic        mem_req;
    logic [4:0]  mem_addr;
    logic        mem_valid = 1'b0;
    logic [63:0] mem_block = '0;

    int n_cmp = 0;
    int n_bad = 0;
    int recent[$];

    always #4 clk = ~clk;

    cache_2way_lru u_cache_2way_lru (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .busy(busy), .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_block(mem_block)
    );

    function automatic logic [7:0] mem_byte(int blk, int k);
        return 8'((blk * 29 + k * 11 + 3) & 255);
    endfunction

    function automatic logic [63:0] mem_blk(int blk);
        logic [63:0] v;
        for (int k = 0; k < 8; k++) v[k*8 +: 8] = mem_byte(blk, k);
        return v;
    endfunction

    // Recency list: front = most recently used; key = set*256 + tag.
    function automatic bit model_access(int set, int tag);
        int key;
        int cnt;
        int last;
        key  = set * 256 + tag;
        cnt  = 0;
        last = -1;
        for (int i = 0; i < recent.size(); i++) begin
            if (recent[i] == key) begin
                recent.delete(i);
                recent.push_front(key);
                return 1'b1;
            end
        end
        for (int i = 0; i < recent.size(); i++) begin
            if (recent[i] / 256 == set) begin
                cnt++;
                last = i;
            end
        end
        if (cnt == 2) recent.delete(last);
        recent.push_front(key);
        return 1'b0;
    endfunction

    task automatic chk(string rq, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic do_read(input logic [7:0] a, input int lat, input bit poke, output bit got_hit);
        int set, tag, off, blk;
        bit exp_hit;
        set = int'(a[3]);
        tag = int'(a[7:4]);
        off = int'(a[2:0]);
        blk = int'(a[7:3]);
        @(negedge clk);
        chk("R8", "busy before request", int'(busy), 0);
        cpu_req  = 1'b1;
        cpu_addr = a;
        exp_hit  = model_access(set, tag);
        @(negedge clk);
        cpu_req = 1'b0;
        got_hit = resp_valid && resp_hit;
        if (exp_hit) begin
            chk("R3", "hit resp_valid", int'(resp_valid), 1);
            chk("R3", "hit resp_hit", int'(resp_hit), 1);
            chk("R2", "hit byte", int'(resp_data), int'(mem_byte(blk, off)));
            chk("R3", "hit mem_req", int'(mem_req), 0);
        end else begin
            chk("R4", "miss mem_req", int'(mem_req), 1);
            chk("R4", "miss busy", int'(busy), 1);
            chk("R2", "miss mem_addr", int'(mem_addr), blk);
            chk("R4", "miss resp_valid", int'(resp_valid), 0);
            for (int i = 0; i < lat; i++) begin
                if (poke) begin
                    cpu_req  = 1'b1;
                    cpu_addr = a ^ 8'h80;
                end
                @(negedge clk);
                cpu_req = 1'b0;
                chk("R4", "wait mem_req", int'(mem_req), 1);
                chk("R8", "wait resp_valid", int'(resp_valid), 0);
                chk("R8", "wait mem_addr", int'(mem_addr), blk);
            end
            mem_valid = 1'b1;
            mem_block = mem_blk(blk);
            @(negedge clk);
            mem_valid = 1'b0;
            mem_block = ~mem_blk(blk);
            chk("R5", "fill resp_valid", int'(resp_valid), 1);
            chk("R5", "fill resp_hit", int'(resp_hit), 0);
            chk("R5", "fill byte", int'(resp_data), int'(mem_byte(blk, off)));
            chk("R5", "fill busy", int'(busy), 0);
            chk("R5", "fill mem_req", int'(mem_req), 0);
        end
    endtask

    task automatic expect_read(input logic [7:0] a, input int lat, input string rq, input string what, input int exp_hit);
        bit h;
        do_read(a, lat, 1'b0, h);
        chk(rq, what, int'(h), exp_hit);
    endtask

    initial begin
        #(8 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL all watchdog expired: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int s;
        bit h;
        repeat (3) @(negedge clk);
        chk("R1", "reset busy", int'(busy), 0);
        chk("R1", "reset resp_valid", int'(resp_valid), 0);
        chk("R1", "reset mem_req", int'(mem_req), 0);
        rst_n = 1'b1;

        // Set 0: fill from empty, then LRU conflicts.
        expect_read(8'h00, 1, "R1", "first read misses", 0);
        expect_read(8'h04, 0, "R3", "same block hits", 1);
        expect_read(8'h14, 2, "R6", "second tag into empty way", 0);
        expect_read(8'h00, 0, "R6", "first tag still resident", 1);
        expect_read(8'h16, 0, "R6", "second tag resident", 1);
        expect_read(8'h01, 0, "R7", "touch tag0 by hit", 1);
        expect_read(8'h24, 3, "R7", "third tag misses", 0);
        expect_read(8'h13, 1, "R7", "tag1 was LRU and evicted", 0);
        expect_read(8'h22, 0, "R7", "tag2 survives", 1);
        expect_read(8'h07, 2, "R7", "tag0 was LRU and evicted", 0);

        // Set 1 independence.
        expect_read(8'h08, 0, "R9", "set1 first miss", 0);
        expect_read(8'h38, 1, "R9", "set1 second miss", 0);
        expect_read(8'h48, 0, "R9", "set1 third miss", 0);
        expect_read(8'h21, 0, "R9", "set0 tag2 untouched", 1);
        expect_read(8'h05, 0, "R9", "set0 tag0 untouched", 1);

        // Requests during a fetch are dropped.
        do_read(8'h5C, 3, 1'b1, h);
        chk("R8", "poked miss result", int'(h), 0);
        expect_read(8'hDC, 0, "R8", "poked address not cached", 0);

        // Stray memory strobe while idle.
        @(negedge clk);
        mem_valid = 1'b1;
        mem_block = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        mem_valid = 1'b0;
        chk("R8", "stray strobe resp_valid", int'(resp_valid), 0);
        chk("R8", "stray strobe busy", int'(busy), 0);
        expect_read(8'h05, 0, "R8", "contents unchanged after strobe", 1);

        // Mixed traffic with varying latency.
        s = 12345;
        for (int n = 0; n < 300; n++) begin
            s = (s * 1103515245 + 12345) & 32'h7FFF_FFFF;
            do_read(8'((s >> 8) & 8'h3F), (s >> 4) % 4, ((s >> 20) & 1) == 1, h);
        end

        // Reset mid-run empties the cache.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "mid reset busy", int'(busy), 0);
        chk("R1", "mid reset resp_valid", int'(resp_valid), 0);
        rst_n = 1'b1;
        recent.delete();
        expect_read(8'h05, 0, "R1", "cached block gone after reset", 0);
        expect_read(8'h05, 0, "R3", "refilled block hits", 1);

        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule